// File: doc/BRIEF.md
# Timer Flag Controller with Selectable Fast Clear

This block is the control-and-status slice of a general-purpose timer. It sits on a simple byte-wide register bus. It holds an 8-bit control register with two live bits: a run enable and a fast-clear mode select. It keeps one event flag per capture/compare channel, an overflow flag for a gated free-running counter, and two pulse-accumulator flags, one for overflow and one for an input edge. Outside logic sends the set events as single-cycle pulses. The block also has two interrupt enable registers and drives one interrupt request line.

Software clears flags in one of two ways, chosen by the fast-clear bit. When the bit is 0, software writes ones to a flag register and each 1 clears its flag (write-one-to-clear). When the bit is 1, writes to the flag registers do nothing to the flags. Instead, ordinary data accesses clear the matching flags as a side effect:
- reading a capture channel or writing a compare channel clears that channel's flag;
- touching the counter bytes clears the counter overflow flag;
- touching the accumulator count bytes clears both accumulator flags.

The bus is a plain strobe interface with no back-pressure. Every access completes in the cycle it is presented. Read data is combinational during a read strobe and zero at all other times. Side effects take place at the clock edge that ends the access.

Top module: `tmr_flag_ctl`

## Requirements
- R1: After reset, every register reads 0, every flag is clear, the counter is 0 and `irq` is low.
- R2: The control register at address 0x00 holds the run enable in bit 7 and fast-clear in bit 4. It can be read and written at any time. Its other bits always read 0, and writing them has no effect.
- R3: The counter advances by one on each clock only while the run enable is 1, and holds otherwise. When it wraps from all-ones to 0, it sets the counter overflow flag (bit 0 of the status flag register at 0x02). While the run enable is 0, the event inputs set no flags.
- R4: With fast-clear 0, a write to the channel flag register (0x01, bit i = channel i) or to the status flag register (0x02; bit 0 counter overflow, bit 1 accumulator overflow, bit 2 accumulator edge) clears each flag written with 1 and leaves each flag written with 0 unchanged.
- R5: With fast-clear 1, writes to 0x01 and 0x02 leave every flag unchanged.
- R6: With fast-clear 1, a read of a capture channel's address (0x10 + i, with `ch_is_capture[i]` = 1) clears that channel's flag. A write to a compare channel's address clears that channel's flag. A write to a capture channel or a read of a compare channel does not clear it.
- R7: With fast-clear 1, any read or write of the counter bytes clears the counter overflow flag. The counter high byte is at 0x05 and the low byte is at 0x06; counter values narrower than 16 bits are zero-extended.
- R8: With fast-clear 1, any read or write of the accumulator count bytes clears both accumulator flags. The high byte is at 0x07 and the low byte is at 0x08; both return `pa_count`.
- R9: When a set event and a clear of the same flag happen in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some flag is set and its enable bit is 1. Channel enables are at 0x03 (bit i = channel i); status enables are at 0x04, using the same bit layout as 0x02.
- R11: A read of 0x10 + i returns `ch_rdata[8i+7:8i]`. A write to 0x10 + i pulses `ch_wr_stb[i]` during that write cycle.
- R12: With fast-clear 0, accesses to channel, counter or accumulator addresses clear no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read strobe is present |
| ch_evt | input | NCH | Per-channel set-event pulses |
| ch_is_capture | input | NCH | 1 = channel is capture, 0 = compare |
| ch_rdata | input | 8*NCH | Channel register read values |
| ch_wr_stb | output | NCH | Channel register write strobes |
| pa_ovf_evt | input | 1 | Accumulator overflow set event |
| pa_edge_evt | input | 1 | Accumulator input-edge set event |
| pa_count | input | 16 | Accumulator count value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NCH = 3 and CNT_W = 8. The 8-bit counter wraps within a few hundred cycles, so the overflow flag and its clear-on-access path can be reached in a short run. With three channels, bits 7 to 3 of the channel flag register are unused, and the bench can check that they read 0. The bench mixes capture and compare channels (channels 0 and 2 capture, channel 1 compare), so each direction-dependent clear of R6 is exercised in both its clearing and non-clearing form.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned VIEW_W  = 16;

  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_CHFLG = 1;
  localparam int unsigned A_MSFLG = 2;
  localparam int unsigned A_CHIEN = 3;
  localparam int unsigned A_MSIEN = 4;
  localparam int unsigned A_CNTH  = 5;
  localparam int unsigned A_CNTL  = 6;
  localparam int unsigned A_PACH  = 7;
  localparam int unsigned A_PACL  = 8;
  localparam int unsigned A_CHBASE = 16;

  localparam int unsigned CTRL_EN_BIT   = 7;
  localparam int unsigned CTRL_FAST_BIT = 4;

  localparam int unsigned MS_CNTOVF = 0;
  localparam int unsigned MS_PAOVF  = 1;
  localparam int unsigned MS_PAEDGE = 2;
  localparam int unsigned MS_W      = 3;

  typedef enum logic [1:0] {ACC_NONE, ACC_RD, ACC_WR} acc_t;
endpackage

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
  import tmr_flag_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic                 wr_chien,
  input  logic                 wr_msien,
  input  logic [REG_W-1:0]     wdata,
  output logic                 ctrl_en,
  output logic                 ctrl_fast,
  output logic [NCH-1:0]       ch_ien,
  output logic [MS_W-1:0]      ms_ien
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_fast <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en   <= wdata[CTRL_EN_BIT];
      ctrl_fast <= wdata[CTRL_FAST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ch_ien <= '0;
    else if (wr_chien) ch_ien <= wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ms_ien <= '0;
    else if (wr_msien) ms_ien <= wdata[MS_W-1:0];
  end
endmodule

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap = run && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_clr_decode.sv
module tmr_clr_decode
  import tmr_flag_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 6
) (
  input  acc_t              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              fast,
  input  logic [NCH-1:0]    ch_is_capture,
  output logic              wr_ctrl,
  output logic              wr_chien,
  output logic              wr_msien,
  output logic [NCH-1:0]    ch_clr,
  output logic [MS_W-1:0]   ms_clr,
  output logic [NCH-1:0]    ch_wr_stb
);
  localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_CHFLG = ADDR_W'(A_CHFLG);
  localparam logic [ADDR_W-1:0] AD_MSFLG = ADDR_W'(A_MSFLG);
  localparam logic [ADDR_W-1:0] AD_CHIEN = ADDR_W'(A_CHIEN);
  localparam logic [ADDR_W-1:0] AD_MSIEN = ADDR_W'(A_MSIEN);
  localparam logic [ADDR_W-1:0] AD_CNTH  = ADDR_W'(A_CNTH);
  localparam logic [ADDR_W-1:0] AD_CNTL  = ADDR_W'(A_CNTL);
  localparam logic [ADDR_W-1:0] AD_PACH  = ADDR_W'(A_PACH);
  localparam logic [ADDR_W-1:0] AD_PACL  = ADDR_W'(A_PACL);

  logic is_rd, is_wr, any_acc;
  logic hit_cnt, hit_pac;
  logic [NCH-1:0] hit_ch;
  logic unused_wbits;

  assign is_rd   = (acc == ACC_RD);
  assign is_wr   = (acc == ACC_WR);
  assign any_acc = is_rd || is_wr;
  assign unused_wbits = ^wdata;

  assign wr_ctrl  = is_wr && (addr == AD_CTRL);
  assign wr_chien = is_wr && (addr == AD_CHIEN);
  assign wr_msien = is_wr && (addr == AD_MSIEN);
  assign hit_cnt  = any_acc && ((addr == AD_CNTH) || (addr == AD_CNTL));
  assign hit_pac  = any_acc && ((addr == AD_PACH) || (addr == AD_PACL));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] AD_CH = ADDR_W'(A_CHBASE + i);
    assign hit_ch[i]    = (addr == AD_CH);
    assign ch_wr_stb[i] = is_wr && hit_ch[i];
  end

  always_comb begin
    ch_clr = '0;
    ms_clr = '0;
    if (!fast) begin
      if (is_wr && addr == AD_CHFLG) ch_clr = wdata[NCH-1:0];
      if (is_wr && addr == AD_MSFLG) ms_clr = wdata[MS_W-1:0];
    end else begin
      for (int i = 0; i < NCH; i++)
        ch_clr[i] = hit_ch[i] && (ch_is_capture[i] ? is_rd : is_wr);
      ms_clr[MS_CNTOVF] = hit_cnt;
      ms_clr[MS_PAOVF]  = hit_pac;
      ms_clr[MS_PAEDGE] = hit_pac;
    end
  end
endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl
  import tmr_flag_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [NCH-1:0]       ch_evt,
  input  logic [NCH-1:0]       ch_is_capture,
  input  logic [REG_W*NCH-1:0] ch_rdata,
  output logic [NCH-1:0]       ch_wr_stb,
  input  logic                 pa_ovf_evt,
  input  logic                 pa_edge_evt,
  input  logic [VIEW_W-1:0]    pa_count,
  output logic                 irq
);
  acc_t                acc;
  logic                ctrl_en, ctrl_fast;
  logic [NCH-1:0]      ch_ien, ch_flags, ch_set, ch_clr;
  logic [MS_W-1:0]     ms_ien, misc_flags, ms_set, ms_clr;
  logic                wr_ctrl, wr_chien, wr_msien;
  logic [CNT_W-1:0]    cnt_q;
  logic                cnt_wrap;
  logic [VIEW_W-1:0]   cnt_view;

  assign acc = !bus_sel ? ACC_NONE : (bus_wr ? ACC_WR : ACC_RD);

  tmr_clr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .acc(acc), .addr(bus_addr), .wdata(bus_wdata), .fast(ctrl_fast),
    .ch_is_capture(ch_is_capture), .wr_ctrl(wr_ctrl), .wr_chien(wr_chien),
    .wr_msien(wr_msien), .ch_clr(ch_clr), .ms_clr(ms_clr), .ch_wr_stb(ch_wr_stb)
  );

  tmr_ctl_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_chien(wr_chien),
    .wr_msien(wr_msien), .wdata(bus_wdata), .ctrl_en(ctrl_en),
    .ctrl_fast(ctrl_fast), .ch_ien(ch_ien), .ms_ien(ms_ien)
  );

  tmr_free_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .cnt(cnt_q), .wrap(cnt_wrap)
  );

  assign ch_set = ch_evt & {NCH{ctrl_en}};
  always_comb begin
    ms_set = '0;
    ms_set[MS_CNTOVF] = cnt_wrap;
    ms_set[MS_PAOVF]  = pa_ovf_evt && ctrl_en;
    ms_set[MS_PAEDGE] = pa_edge_evt && ctrl_en;
  end

  tmr_flag_bank #(.W(NCH)) u_chflg (
    .clk(clk), .rst_n(rst_n), .set(ch_set), .clr(ch_clr), .flags(ch_flags)
  );

  tmr_flag_bank #(.W(MS_W)) u_msflg (
    .clk(clk), .rst_n(rst_n), .set(ms_set), .clr(ms_clr), .flags(misc_flags)
  );

  assign cnt_view = VIEW_W'(cnt_q);
  assign irq = (|(ch_flags & ch_ien)) || (|(misc_flags & ms_ien));

  always_comb begin
    bus_rdata = '0;
    if (acc == ACC_RD) begin
      unique case (bus_addr)
        ADDR_W'(A_CTRL): begin
          bus_rdata[CTRL_EN_BIT]   = ctrl_en;
          bus_rdata[CTRL_FAST_BIT] = ctrl_fast;
        end
        ADDR_W'(A_CHFLG): bus_rdata = REG_W'(ch_flags);
        ADDR_W'(A_MSFLG): bus_rdata = REG_W'(misc_flags);
        ADDR_W'(A_CHIEN): bus_rdata = REG_W'(ch_ien);
        ADDR_W'(A_MSIEN): bus_rdata = REG_W'(ms_ien);
        ADDR_W'(A_CNTH):  bus_rdata = cnt_view[VIEW_W-1:REG_W];
        ADDR_W'(A_CNTL):  bus_rdata = cnt_view[REG_W-1:0];
        ADDR_W'(A_PACH):  bus_rdata = pa_count[VIEW_W-1:REG_W];
        ADDR_W'(A_PACL):  bus_rdata = pa_count[REG_W-1:0];
        default: begin
          for (int i = 0; i < NCH; i++)
            if (bus_addr == ADDR_W'(A_CHBASE + i))
              bus_rdata = ch_rdata[i*REG_W +: REG_W];
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_flag_ctl_chk.sv
module tmr_flag_ctl_chk
  import tmr_flag_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              ctrl_en,
  input logic              ctrl_fast,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              cnt_wrap,
  input logic [NCH-1:0]    ch_evt,
  input logic [NCH-1:0]    ch_flags,
  input logic [MS_W-1:0]   misc_flags,
  input logic              irq
);
  logic ctrl_rd, flag_wr, cnt_acc;
  assign ctrl_rd = bus_sel && !bus_wr && bus_addr == ADDR_W'(A_CTRL);
  assign flag_wr = bus_sel && bus_wr &&
                   (bus_addr == ADDR_W'(A_CHFLG) || bus_addr == ADDR_W'(A_MSFLG));
  assign cnt_acc = bus_sel &&
                   (bus_addr == ADDR_W'(A_CNTH) || bus_addr == ADDR_W'(A_CNTL));

  assert_ctrl_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |-> (bus_rdata[6:5] == 2'b00 && bus_rdata[3:0] == 4'h0));

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> $stable(cnt_q));

  assert_fast_flagwr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_fast && flag_wr) |=>
      ((ch_flags & $past(ch_flags)) == $past(ch_flags) &&
       (misc_flags & $past(misc_flags)) == $past(misc_flags)));

  assert_fast_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_fast && cnt_acc && !cnt_wrap) |=> !misc_flags[MS_CNTOVF]);

  assert_normal_no_side_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_fast && !flag_wr) |=>
      ((ch_flags & $past(ch_flags)) == $past(ch_flags) &&
       (misc_flags & $past(misc_flags)) == $past(misc_flags)));

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ch_flags != '0 || misc_flags != '0));

  for (genvar i = 0; i < NCH; i++) begin : g_set
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && ch_evt[i]) |=> ch_flags[i]);
  end
endmodule

bind tmr_flag_ctl tmr_flag_ctl_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ctrl_en(ctrl_en),
  .ctrl_fast(ctrl_fast), .cnt_q(cnt_q), .cnt_wrap(cnt_wrap), .ch_evt(ch_evt),
  .ch_flags(ch_flags), .misc_flags(misc_flags), .irq(irq)
);

// File: tb/tb_tmr_flag_ctl.sv
module tb_tmr_flag_ctl;
  localparam int NCH = 3;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] ch_evt = '0, ch_wr_stb;
  logic [NCH-1:0] ch_is_capture = 3'b101;
  logic [8*NCH-1:0] ch_rdata = 24'h33_22_11;
  logic pa_ovf_evt = 1'b0, pa_edge_evt = 1'b0;
  logic [15:0] pa_count = 16'hBEEF;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  tmr_flag_ctl #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_evt(ch_evt), .ch_is_capture(ch_is_capture), .ch_rdata(ch_rdata),
    .ch_wr_stb(ch_wr_stb), .pa_ovf_evt(pa_ovf_evt), .pa_edge_evt(pa_edge_evt),
    .pa_count(pa_count), .irq(irq)
  );

  // monitor: pops the scoreboard on every read strobe, mid-cycle
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected read, actual %h expected none", "scoreboard", bus_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic wr_evt(input logic [5:0] a, input logic [7:0] d, input logic [NCH-1:0] ev);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; ch_evt = ev;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; ch_evt = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic pulse(input logic [NCH-1:0] ev, input logic po, input logic pe);
    @(posedge clk); #1;
    ch_evt = ev; pa_ovf_evt = po; pa_edge_evt = pe;
    @(posedge clk); #1;
    ch_evt = '0; pa_ovf_evt = 0; pa_edge_evt = 0;
  endtask

  task automatic chk1(input logic act, input logic ex, input string t);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, ex);
    end
  endtask

  task automatic wr_stb(input logic [5:0] a, input logic [NCH-1:0] ex, input string t);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = 8'h5A;
    @(negedge clk);
    checks++;
    if (ch_wr_stb !== ex) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, ch_wr_stb, ex);
    end
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(6'h00, 8'h00, "R1 ctrl");
    rd(6'h01, 8'h00, "R1 chflg");
    rd(6'h02, 8'h00, "R1 msflg");
    rd(6'h06, 8'h00, "R1 cntlo");
    @(negedge clk); chk1(irq, 1'b0, "R1 irq");
    // R3 disabled: events ignored
    pulse(3'b111, 1, 1);
    rd(6'h01, 8'h00, "R3 gated ch");
    rd(6'h02, 8'h00, "R3 gated misc");
    // R3 counter runs exactly while enabled
    wr(6'h00, 8'h80);
    repeat (10) @(posedge clk);
    wr(6'h00, 8'h00);
    rd(6'h06, 8'd12, "R3 count lo");
    rd(6'h05, 8'h00, "R3 count hi");
    // R2 control bits
    wr(6'h00, 8'hFF);
    rd(6'h00, 8'h90, "R2 ctrl ones");
    wr(6'h00, 8'h6F);
    rd(6'h00, 8'h00, "R2 ctrl unused");
    // events with enable, normal mode
    wr(6'h00, 8'h80);
    pulse(3'b111, 1, 1);
    rd(6'h01, 8'h07, "R3 ch set");
    rd(6'h02, 8'h06, "R3 pa set");
    // R10 irq
    @(negedge clk); chk1(irq, 1'b0, "R10 irq masked");
    wr(6'h03, 8'h02); @(negedge clk); chk1(irq, 1'b1, "R10 ch irq");
    wr(6'h03, 8'h00); @(negedge clk); chk1(irq, 1'b0, "R10 ch irq off");
    wr(6'h04, 8'h04); @(negedge clk); chk1(irq, 1'b1, "R10 pa irq");
    wr(6'h04, 8'h00);
    // R12 / R11 no side clears in normal mode
    rd(6'h10, 8'h11, "R11 ch0 data");
    wr_stb(6'h11, 3'b010, "R11 ch1 strobe");
    rd(6'h05, 8'h00, "R12 cnt access");
    rd(6'h08, 8'hEF, "R12 pa lo");
    rd(6'h01, 8'h07, "R12 ch kept");
    rd(6'h02, 8'h06, "R12 misc kept");
    // R4 write-one-to-clear
    wr(6'h01, 8'h05);
    rd(6'h01, 8'h02, "R4 ch w1c");
    wr(6'h02, 8'h02);
    rd(6'h02, 8'h04, "R4 misc w1c");
    // R9 set wins
    wr_evt(6'h01, 8'h02, 3'b010);
    rd(6'h01, 8'h02, "R9 set wins");
    wr(6'h01, 8'h02);
    rd(6'h01, 8'h00, "R4 cleared");
    // fast mode
    wr(6'h00, 8'h90);
    pulse(3'b111, 1, 1);
    rd(6'h02, 8'h06, "R5 misc pre");
    wr(6'h01, 8'hFF);
    wr(6'h02, 8'hFF);
    rd(6'h01, 8'h07, "R5 ch kept");
    rd(6'h02, 8'h06, "R5 misc kept");
    // R6
    wr(6'h10, 8'h00);
    rd(6'h01, 8'h07, "R6 capture write no clr");
    rd(6'h11, 8'h22, "R11 ch1 data");
    rd(6'h01, 8'h07, "R6 compare read no clr");
    rd(6'h10, 8'h11, "R6 ch0 read");
    rd(6'h01, 8'h06, "R6 capture read clr");
    wr(6'h11, 8'h00);
    rd(6'h01, 8'h04, "R6 compare write clr");
    rd(6'h12, 8'h33, "R6 ch2 read");
    rd(6'h01, 8'h00, "R6 all clr");
    // R8
    rd(6'h07, 8'hBE, "R8 pa hi");
    rd(6'h02, 8'h00, "R8 both clr");
    pulse(3'b000, 0, 1);
    wr(6'h08, 8'h00);
    rd(6'h02, 8'h00, "R8 write clr");
    // R3 overflow and R7 clear on read
    repeat (300) @(posedge clk);
    wr(6'h00, 8'h10);
    rd(6'h02, 8'h01, "R3 overflow");
    rd(6'h05, 8'h00, "R7 cnt hi read");
    rd(6'h02, 8'h00, "R7 read clr");
    // R7 clear on write
    wr(6'h00, 8'h90);
    repeat (300) @(posedge clk);
    wr(6'h00, 8'h10);
    rd(6'h02, 8'h01, "R3 overflow again");
    wr(6'h06, 8'h55);
    rd(6'h02, 8'h00, "R7 write clr");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule